// File: doc/BRIEF.md
# Period-Measuring Capture Timer

This block is a 16-bit up-counting timer with auto-reload that can also measure how long a slow external event lasts, counted in fast clock ticks. The counter advances on every system clock, or on every twelfth system clock when the divided rate is chosen. Software sets it up through a small byte-wide register port. Software sees that an event has occurred through a sticky flag and an interrupt line.

With capture enabled, an event fires on each rising edge of a comparator input, or once for every eight rising edges of a slow clock input. Both inputs are asynchronous to the system clock. On each event the running count is copied into the reload register pair and the flag is set. Software takes the difference between two successive captured values as the period. With the slow source, that difference covers eight slow cycles. Because capture reuses the reload registers, the counter does not reload while capture is on. It wraps freely through zero instead.

Top module: `period_capture_timer`

## Requirements
- R1: After reset every register reads 0 (control at address 0, count low/high at 1/2, reload low/high at 3/4) and `irq` is low.
- R2: With control bit 0 (run) set and bit 3 (divided rate) clear, the count rises by one per system clock. With run clear and no count write, the count holds.
- R3: With bit 3 set, the count rises once every 12 system clocks, so captured differences are in units of 12 system clocks.
- R4: With bit 1 (capture enable) clear, a count step from 0xFFFF loads the reload value and sets the flag (control bit 7).
- R5: With capture enable set, a count step from 0xFFFF gives 0x0000, the reload registers are left unchanged, and the flag is set.
- R6: With capture enable set and bit 2 = 1, each comparator rising edge copies the count into the reload pair and sets the flag. The copy happens on the third clock edge after the input is first sampled high, so successive captures differ by the edge spacing.
- R7: With capture enable set and bit 2 = 0, a capture happens only on every eighth slow-clock rising edge, counted from reset. The reload pair is unchanged between captures.
- R8: `irq` is high exactly when the flag is set and control bit 4 (interrupt enable) is set.
- R9: Writing control with bit 7 = 0 clears the flag, and writing bit 7 = 1 leaves it as it was. A capture in the same cycle as a clearing write leaves the flag set.
- R10: A software write to a reload byte in the same cycle as a capture is discarded, and the captured value is kept.
- R11: Captures happen whether the run bit is set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cmp_in | input | 1 | Asynchronous comparator output |
| slow_clk_in | input | 1 | Asynchronous slow clock |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer, a prescale of 12 and a slow-clock divide of 8. The input-to-capture latency is therefore three clock edges. That fixed latency lets the bench place a clearing write or a reload write in exactly the cycle of a capture. With the counter stopped, the captured value is a known constant. The prescale of 12 keeps divided-rate period measurements short enough to run many random periods. The divide of 8 allows several complete slow-clock events within the cycle budget.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_CNT_LO = 3'd1,
    ADR_CNT_HI = 3'd2,
    ADR_RLD_LO = 3'd3,
    ADR_RLD_HI = 3'd4
  } pct_addr_e;

  // control byte bits 4..0; bit 7 is the flag, kept outside this struct
  typedef struct packed {
    logic irq_en;
    logic div_slow;
    logic sel_cmp;
    logic cap_en;
    logic run;
  } pct_ctrl_t;

  localparam int CTRL_W   = $bits(pct_ctrl_t);
  localparam int FLAG_BIT = 7;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic is_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  function automatic logic [CNT_W-1:0] ticks_between(input logic [CNT_W-1:0] older,
                                                     input logic [CNT_W-1:0] newer);
    return newer - older;
  endfunction
endpackage

// File: rtl/pct_edge_sync.sv
module pct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // one pulse per edge, never two in a row
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_div,
  output logic tick
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + PW'(1);
  end

  assign tick = use_div ? (pre_q == LAST) : 1'b1;

  // divided rate: a tick is never followed by another while still divided
  assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_div && tick) |=> (!use_div || !tick));
endmodule

// File: rtl/pct_event_div.sv
module pct_event_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  output logic evt
);
  localparam int DW = $clog2(DIV);
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else if (in_pulse) div_q <= (div_q == LAST) ? '0 : div_q + DW'(1);
  end

  assign evt = in_pulse && (div_q == LAST);
endmodule

// File: rtl/pct_counter.sv
module pct_counter
  import pct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             free_run,
  input  logic [CNT_W-1:0] reload,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic             sw_wr;
  logic             step;

  assign sw_wr = wr_lo | wr_hi;
  assign step  = tick && run && !sw_wr;
  assign wrap  = step && is_top(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) cnt_q[BYTE_W-1:0]     <= wr_byte;
      if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_byte;
    end else if (step) begin
      if (wrap) cnt_q <= free_run ? '0 : reload;
      else      cnt_q <= step_count(cnt_q);
    end
  end

  assign count = cnt_q;

  assert_reload_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !free_run) |=> (count == $past(reload)));

  assert_free_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && free_run) |=> (count == '0));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_wr) |=> (count == $past(count)));
endmodule

// File: rtl/period_capture_timer.sv
module period_capture_timer
  import pct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 12,
  parameter int SLOW_DIV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cmp_in,
  input  logic              slow_clk_in,
  output logic              irq
);
  pct_ctrl_t        ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;

  // named internal events
  logic cmp_rise, slow_rise, slow_evt, cap_evt, tick, wrap;
  logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi, clr_req;

  assign wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_cnt_lo = reg_wr && (reg_addr == ADR_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == ADR_CNT_HI);
  assign wr_rld_lo = reg_wr && (reg_addr == ADR_RLD_LO);
  assign wr_rld_hi = reg_wr && (reg_addr == ADR_RLD_HI);
  assign clr_req   = wr_ctrl && !reg_wdata[FLAG_BIT];

  pct_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise));

  pct_edge_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk_in), .rise(slow_rise));

  pct_event_div #(.DIV(SLOW_DIV)) u_slow_div (
    .clk(clk), .rst_n(rst_n), .in_pulse(slow_rise), .evt(slow_evt));

  pct_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .use_div(ctrl_q.div_slow), .tick(tick));

  assign cap_evt = ctrl_q.cap_en && (ctrl_q.sel_cmp ? cmp_rise : slow_evt);

  pct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run),
    .free_run(ctrl_q.cap_en), .reload(reload_q),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wr_byte(reg_wdata),
    .count(count), .wrap(wrap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= pct_ctrl_t'(reg_wdata[CTRL_W-1:0]);

      if (cap_evt || wrap) flag_q <= 1'b1;
      else if (clr_req)    flag_q <= 1'b0;

      if (cap_evt) begin
        reload_q <= count;
      end else begin
        if (wr_rld_lo) reload_q[BYTE_W-1:0]     <= reg_wdata;
        if (wr_rld_hi) reload_q[CNT_W-1:BYTE_W] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:   reg_rdata = {flag_q, {(BYTE_W-CTRL_W-1){1'b0}}, ctrl_q};
      ADR_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      ADR_CNT_HI: reg_rdata = count[CNT_W-1:BYTE_W];
      ADR_RLD_LO: reg_rdata = reload_q[BYTE_W-1:0];
      ADR_RLD_HI: reg_rdata = reload_q[CNT_W-1:BYTE_W];
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = flag_q && ctrl_q.irq_en;

  assert_capture_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (reload_q == $past(count)));

  assert_capture_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && clr_req) |=> flag_q);

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !cap_evt && !wrap) |=> !flag_q);

  assert_reload_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !wr_rld_lo && !wr_rld_hi) |=> $stable(reload_q));
endmodule

// File: tb/period_capture_timer_bench.sv
`timescale 1ns/1ps
module period_capture_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmp_in = 1'b0;
  logic       slow_clk_in = 1'b0;
  logic       irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int unsigned seed_sink;
  longint elapsed = 0;

  always #2 clk = ~clk;

  period_capture_timer u_period_capture_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .slow_clk_in(slow_clk_in), .irq(irq));

  // expected-value helpers restated from the requirements
  function automatic logic [7:0] ctl(bit run, bit cap, bit cmp, bit dv, bit ien, bit keep);
    return {keep, 2'b00, ien, dv, cmp, cap, run};
  endfunction
  function automatic int exp_delta(int sys_cycles, bit dv);
    return dv ? sys_cycles / 12 : sys_cycles;
  endfunction
  function automatic logic [15:0] diff16(logic [15:0] a, logic [15:0] b);
    return 16'(b - a);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    elapsed += n;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #0.3; v = reg_rdata;
  endtask

  task automatic rd16(logic [2:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo); rd(a_lo + 3'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, prev;
    int p, prev_p;
    longint t_prev;
    bit have_prev;
    seed_sink = $urandom(32'd20240611);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      check(b == 8'h00, "R1 reset register", b, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2 counting at full rate, then hold
    wr(3'd0, ctl(1, 0, 0, 0, 0, 1));
    tick(37);
    rd16(3'd1, v);
    check(v == 16'd37, "R2 full-rate count", v, 37);
    wr(3'd0, ctl(0, 0, 0, 0, 0, 1));
    tick(10);
    rd16(3'd1, v);
    check(v == 16'd38, "R2 hold when stopped", v, 38);

    // R4 reload on wrap, capture off
    wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0));
    tick(2);
    rd16(3'd1, v); rd(3'd0, b);
    check(v == 16'hFFFF && !b[7], "R4 before wrap", {b, v}, 16'hFFFF);
    tick(1);
    rd16(3'd1, v); rd(3'd0, b);
    check(v == 16'h1234, "R4 reload value", v, 16'h1234);
    check(b[7], "R4 flag on wrap", b[7], 1);

    // R8 interrupt gating and R9 clear behaviour
    wr(3'd0, ctl(0, 0, 0, 0, 0, 1));
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(3'd0, ctl(0, 0, 0, 0, 1, 1));
    check(irq == 1'b1, "R8 irq enabled", irq, 1);
    wr(3'd0, ctl(0, 0, 0, 0, 1, 0));
    rd(3'd0, b);
    check(!b[7] && irq == 1'b0, "R9 clear by writing 0", {b[7], irq}, 0);
    wr(3'd0, ctl(0, 0, 0, 0, 1, 1));
    rd(3'd0, b);
    check(!b[7], "R9 writing 1 does not set", b[7], 0);

    // R5 free wrap in capture mode
    wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
    wr(3'd0, ctl(1, 1, 1, 0, 0, 1));
    tick(3);
    rd16(3'd1, v);
    check(v == 16'h0000, "R5 wraps to zero", v, 0);
    rd16(3'd3, v); rd(3'd0, b);
    check(v == 16'h1234, "R5 reload untouched", v, 16'h1234);
    check(b[7], "R5 flag on wrap", b[7], 1);

    // R11 + R10: capture while stopped, colliding reload write
    wr(3'd0, ctl(0, 1, 1, 0, 0, 0));
    wr(3'd1, 8'hB0); wr(3'd2, 8'h0A);
    cmp_in = 1'b1;
    tick(2);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h55;
    tick(1);
    reg_wr = 1'b0;
    rd16(3'd3, v); rd(3'd0, b);
    check(v == 16'h0AB0, "R10 reload write dropped on capture", v, 16'h0AB0);
    check(b[7], "R11 capture with run clear sets flag", b[7], 1);
    tick(2);
    wr(3'd3, 8'h66);
    rd16(3'd3, v);
    check(v == 16'h0A66, "R10 reload write accepted otherwise", v, 16'h0A66);

    // R9 capture beats a same-cycle clear
    cmp_in = 1'b0;
    tick(4);
    cmp_in = 1'b1;
    tick(2);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = ctl(0, 1, 1, 0, 0, 0);
    tick(1);
    reg_wr = 1'b0;
    rd(3'd0, b);
    check(b[7], "R9 capture wins over clear", b[7], 1);
    cmp_in = 1'b0;
    tick(4);
    wr(3'd0, ctl(0, 1, 1, 0, 0, 0));

    // R6 / R3 random comparator periods at both rates
    for (int dv = 0; dv < 2; dv++) begin
      wr(3'd1, 8'h00); wr(3'd2, 8'h00);
      wr(3'd0, ctl(1, 1, 1, dv[0], 0, 1));
      have_prev = 0; prev_p = 0; prev = '0;
      for (int i = 0; i < 7; i++) begin
        p = dv ? 12 * (2 + int'($urandom % 15)) : 20 + int'($urandom % 180);
        cmp_in = 1'b1;
        tick(4);
        rd16(3'd3, v);
        if (have_prev)
          check(diff16(prev, v) == 16'(exp_delta(prev_p, dv[0])),
                dv ? "R3 divided-rate capture delta" : "R6 comparator capture delta",
                diff16(prev, v), exp_delta(prev_p, dv[0]));
        prev = v; prev_p = p; have_prev = 1;
        tick(1);
        cmp_in = 1'b0;
        tick(p - 5);
      end
    end

    // R7 slow-clock captures on every eighth edge
    wr(3'd0, ctl(1, 1, 0, 0, 0, 1));
    have_prev = 0; t_prev = 0; prev = '0;
    for (int k = 1; k <= 32; k++) begin
      p = 8 + int'($urandom % 13);
      slow_clk_in = 1'b1;
      if (k % 8 == 0) begin
        longint t_now;
        t_now = elapsed;
        tick(4);
        rd16(3'd3, v);
        if (have_prev)
          check(diff16(prev, v) == 16'(t_now - t_prev), "R7 eight-edge capture delta",
                diff16(prev, v), t_now - t_prev);
        prev = v; t_prev = t_now; have_prev = 1;
      end else begin
        tick(4);
        if (have_prev && k % 8 == 4) begin
          rd16(3'd3, v);
          check(v == prev, "R7 no capture between events", v, prev);
        end
      end
      tick(1);
      slow_clk_in = 1'b0;
      tick(p - 5);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule